// File: doc/BRIEF.md
# Programmable-Modulus Cascadable Digit Counter

This block is one digit of a clock built from cascaded synchronous counters. It counts upward from zero to a terminal value that arrives on a configuration input at run time, then returns to zero. Because the terminal value is an input, the same design serves every digit position: seconds-units, seconds-tens, minutes, hours.

A stage advances on a rising clock edge when its carry-in is high or its manual-advance input is held. The manual-advance path lets an operator set the time by holding a button. It needs no debouncing because it is only sampled at the clock edge.

A stage returns to zero only when it sits on its terminal value and carry-in is high at the same time. The same condition drives an active-low carry-out, which is inverted and fed to the carry-in of the next stage. Six stages chained this way form a full clock.

Top module: `digit_counter`

## Requirements
- R1: An active-low asynchronous reset forces the count to zero at once, without waiting for a clock edge.
- R2: While enabled, and not wrapping, the count rises by exactly one on each rising clock edge.
- R3: The stage is enabled when carry-in is high or the manual-advance input is high. With both inputs low, the count holds its value across clock edges.
- R4: A terminal match exists when every bit of the count equals the corresponding bit of the terminal value input.
- R5: When a terminal match and a high carry-in are present together, the next rising clock edge loads zero into the count.
- R6: The carry-out is active low. It is low combinationally exactly while a terminal match and a high carry-in coincide, and high otherwise.
- R7: When manual-advance moves a stage that is at its terminal value while carry-in is low, no load occurs. The count steps to the terminal value plus one.
- R8: Counting up from the all-ones value (15 at the default width) rolls over to zero.
- R9: The terminal value is read at run time. Changing it moves the wrap point and immediately changes the carry-out.
- R10: Stages chained with each inverted carry-out driving the next carry-in, and the first stage's carry-in held high, count as a mixed-radix number. Digit k has radix equal to its terminal value plus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock (the counting tick) |
| rst_n | input | 1 | Asynchronous reset, active low |
| carry_in | input | 1 | Carry from the previous stage, active high |
| advance | input | 1 | Manual advance request, sampled at the clock edge |
| term_val | input | W | Terminal value; the count wraps to zero after it |
| count | output | W | Current digit value |
| carry_out_n | output | 1 | Carry to the next stage, active low |

## Verification
The bench uses the default width of four for a single stage. At that width a few dozen cycles cover the slip past the terminal value and the rollover from 15 to zero. A second group of six stages, also four bits wide, uses small terminal values of 1 and 2 that alternate from stage to stage. This gives a total period of 216 counts, so a run of 250 ticks carries through every stage and also wraps the most significant one. The bench then compares the result against a mixed-radix value it computes itself.

// File: rtl/digit_counter.sv
module digit_counter #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         carry_in,
  input  logic         advance,
  input  logic [W-1:0] term_val,
  output logic [W-1:0] count,
  output logic         carry_out_n
);

  logic at_term;
  logic wrap;
  logic step_en;

  assign at_term     = (count == term_val);
  assign wrap        = at_term & carry_in;
  assign step_en     = carry_in | advance;
  assign carry_out_n = ~wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (wrap)    count <= '0;
    else if (step_en) count <= count + W'(1);
  end

  // R5
  wrap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (carry_in && count == term_val) |=> (count == '0));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!carry_in && !advance) |=> $stable(count));

  // R2
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((carry_in || advance) && carry_out_n) |=> (count == $past(count) + W'(1)));

  // R7
  slip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !carry_in && count == term_val) |=> (count == $past(term_val) + W'(1)));

endmodule

// File: tb/digit_counter_tb_top.sv
module digit_counter_tb_top;
  localparam int W = 4;
  localparam int NST = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ci = 1'b0;
  logic adv = 1'b0;
  logic [W-1:0] tv = 4'd9;
  logic [W-1:0] cnt;
  logic co_n;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  digit_counter #(.W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .carry_in(ci), .advance(adv),
    .term_val(tv), .count(cnt), .carry_out_n(co_n)
  );

  logic chain_en = 1'b0;
  logic [NST:0] link;
  logic [NST-1:0] link_n;
  logic [W-1:0] digit [NST];
  assign link[0] = chain_en;

  for (genvar k = 0; k < NST; k++) begin : g_chain
    digit_counter #(.W(W)) stage_i (
      .clk(clk), .rst_n(rst_n), .carry_in(link[k]), .advance(1'b0),
      .term_val((k % 2 == 0) ? 4'd1 : 4'd2), .count(digit[k]),
      .carry_out_n(link_n[k])
    );
    assign link[k+1] = ~link_n[k];
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    check("R1 count in reset", cnt, 0);
    check("R6 carry_out idle", co_n, 1);
    tick(1);
    rst_n = 1'b1;
    tick(1);
    check("R1 count after reset", cnt, 0);
  endtask

  task automatic t_count;
    ci = 1'b1; tv = 4'd9;
    for (int i = 1; i <= 5; i++) begin
      tick(1);
      check("R2 increment", cnt, i);
    end
    check("R6 no match carry high", co_n, 1);
  endtask

  task automatic t_hold;
    ci = 1'b0; adv = 1'b0;
    tick(3);
    check("R3 hold", cnt, 5);
    adv = 1'b1;
    tick(1);
    check("R3 advance enables", cnt, 6);
    adv = 1'b0;
  endtask

  task automatic t_wrap;
    ci = 1'b1;
    tick(3);
    check("R4 at terminal", cnt, 9);
    check("R6 carry low on match", co_n, 0);
    tick(1);
    check("R5 wrap to zero", cnt, 0);
    check("R6 carry high after wrap", co_n, 1);
  endtask

  task automatic t_slip;
    ci = 1'b0; adv = 1'b1; tv = 4'd3;
    tick(3);
    check("R7 at terminal", cnt, 3);
    check("R6 carry high without carry_in", co_n, 1);
    tick(1);
    check("R7 stepped past", cnt, 4);
    tick(11);
    check("R8 at all ones", cnt, 15);
    tick(1);
    check("R8 rollover", cnt, 0);
  endtask

  task automatic t_runtime;
    tick(4);
    adv = 1'b0;
    check("R9 setup", cnt, 4);
    tv = 4'd4; ci = 1'b1;
    #0.5;
    check("R9 carry low at new terminal", co_n, 0);
    tv = 4'd7;
    #0.5;
    check("R9 carry released", co_n, 1);
    tick(1);
    check("R9 no wrap at old terminal", cnt, 5);
    ci = 1'b0;
  endtask

  task automatic t_chain;
    int n;
    @(negedge clk);
    rst_n = 1'b0;
    tick(1);
    rst_n = 1'b1;
    chain_en = 1'b1;
    tick(250);
    chain_en = 1'b0;
    n = 250;
    for (int k = 0; k < NST; k++) begin
      int r;
      r = (k % 2 == 0) ? 2 : 3;
      check($sformatf("R10 digit %0d", k), digit[k], n % r);
      n = n / r;
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_count();
    t_hold();
    t_wrap();
    t_slip();
    t_runtime();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule